// File: doc/BRIEF.md
# Local Sequence Alignment Scoring Array

This block computes a local alignment score matrix between a short query sequence and a longer database sequence of DNA symbols, coded in two bits. It is a linear chain of processing elements, and each element holds one query symbol. The query is written into the elements one index at a time while the block is idle.

Database symbols then stream in, at most one per clock, and pass down the chain. Element i computes row i of the matrix. Symbol j reaches element i in the cycle after it reaches element i−1, so the cells of one anti-diagonal are computed in the same cycle. Work on successive database symbols overlaps along the chain.

For each database symbol the block emits the last-row score of the matrix. This output is marked by a valid strobe and comes out a fixed number of cycles after the symbol enters. A last-symbol flag closes one database sequence, so that the next accepted symbol starts a fresh matrix.

Top module: `seq_align_top`

## Requirements
- R1: Row 0 and column 0 of the score matrix are zero: the first symbol of every database sequence is scored with zero left and zero upper-left neighbours, and element 1 always sees a zero upper neighbour.
- R2: For i ≥ 1 and j ≥ 1, cell M[i,j] equals the largest of 0, M[i,j−1]−8, M[i−1,j]−8 and M[i−1,j−1]+s(i,j).
- R3: s(i,j) is +15 when query symbol i equals database symbol j and −12 otherwise. Symbols are compared as 2-bit codes.
- R4: For every accepted database symbol j, the block outputs exactly one score, M[NUM_PE,j]. These scores appear in the order of j.
- R5: The score for a symbol accepted at a clock edge appears with resValid high after exactly NUM_PE clock edges, counting that edge. resValid is low in every other cycle.
- R6: A cycle with dbValid low advances no matrix column and leaves every element's stored neighbour scores unchanged.
- R7: A symbol accepted with dbLast high ends the current sequence. The next accepted symbol becomes column 1 of a new matrix, whatever the earlier scores were.
- R8: A write with qryWe high stores qrySym as query symbol qryIdx+1 (qryIdx 0 addresses row 1). Only that element changes, and the new symbol takes effect for symbols accepted afterwards.
- R9: After reset, resValid is 0 and resScore is 0.
- R10: Scores never go below zero, so a database sequence that matches no query symbol gives a score of 0 at every position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| qryWe | input | 1 | Query symbol write enable |
| qryIdx | input | $clog2(NUM_PE) | Query index; 0 addresses row 1 |
| qrySym | input | SYM_W | Query symbol to store |
| dbValid | input | 1 | Database symbol valid |
| dbSym | input | SYM_W | Database symbol |
| dbLast | input | 1 | Marks the last symbol of a database sequence |
| resValid | output | 1 | Result score valid |
| resScore | output | SCORE_W | Last-row score M[NUM_PE,j] |

## Verification
Every result is due a fixed NUM_PE clock edges after its symbol is accepted, whatever bubbles or sequence boundaries surround it. The bench therefore builds a cycle-by-cycle schedule of which symbol, if any, it drives on each falling edge. On each later falling edge it compares the output against the symbol driven NUM_PE cycles earlier, or checks that resValid is low if that slot was a bubble. Expected scores come from a dynamic-programming model in the bench. This makes misplaced valids, off-by-one latency and any stray output visible in the exact cycle they occur.

// File: rtl/seq_align_pkg.sv
package seq_align_pkg;

  // Per-cycle strobes from control to the array.
  typedef struct packed {
    logic stepEn;    // a database symbol enters element 1 this cycle
    logic colStart;  // that symbol is column 1 of a new matrix
  } alnStrb_t;

endpackage

// File: rtl/seq_align_pe.sv
module seq_align_pe #(
  parameter int SYM_W    = 2,
  parameter int SCORE_W  = 16,
  parameter int MATCH_SC = 15,
  parameter int MISS_SC  = 12,
  parameter int GAP_SC   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               qryEn,
  input  logic [SYM_W-1:0]   qrySym,
  input  logic               inValid,
  input  logic               inStart,
  input  logic [SYM_W-1:0]   inSym,
  input  logic [SCORE_W-1:0] inUp,
  output logic               outValid,
  output logic               outStart,
  output logic [SYM_W-1:0]   outSym,
  output logic [SCORE_W-1:0] outScore
);

  logic [SYM_W-1:0]   qSym;
  logic [SCORE_W-1:0] diagR;   // M[i-1,j-1]
  logic [SCORE_W-1:0] leftR;   // M[i,j-1]
  logic [SCORE_W-1:0] bestScore;

  int diagI, leftI, upI, candI, bestI;

  always_comb begin
    diagI = inStart ? 0 : int'(diagR);
    leftI = inStart ? 0 : int'(leftR);
    upI   = int'(inUp);
    bestI = 0;
    candI = diagI + ((inSym == qSym) ? MATCH_SC : -MISS_SC);
    if (candI > bestI) bestI = candI;
    candI = leftI - GAP_SC;
    if (candI > bestI) bestI = candI;
    candI = upI - GAP_SC;
    if (candI > bestI) bestI = candI;
    bestScore = SCORE_W'(bestI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qSym <= '0;
    end else if (qryEn) begin
      qSym <= qrySym;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outStart <= 1'b0;
      outSym   <= '0;
      outScore <= '0;
      diagR    <= '0;
      leftR    <= '0;
    end else begin
      outValid <= inValid;
      outStart <= inValid & inStart;
      if (inValid) begin
        outSym   <= inSym;
        outScore <= bestScore;
        diagR    <= inUp;
        leftR    <= bestScore;
      end
    end
  end

  // R2: a cell is never more than one gap below its left neighbour
  a_r2_left_gap: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inStart) |=> (int'(outScore) + GAP_SC >= int'($past(leftR))));

  // R2: a cell is never more than one gap below its upper neighbour
  a_r2_up_gap: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (int'(outScore) + GAP_SC >= int'($past(inUp))));

  // R1: column 1 cells cannot exceed a single match
  a_r1_first_col: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inStart) |=> (int'(outScore) <= MATCH_SC));

  // R6: bubbles leave the stored neighbours alone
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(leftR) && $stable(diagR) && !outValid));

endmodule

// File: rtl/seq_align_ctrl.sv
module seq_align_ctrl
  import seq_align_pkg::*;
#(
  parameter int NUM_PE = 8,
  localparam int IDX_W = $clog2(NUM_PE)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dbValid,
  input  logic             dbLast,
  input  logic             qryWe,
  input  logic [IDX_W-1:0] qryIdx,
  output alnStrb_t         strb,
  output logic [NUM_PE-1:0] qryEn
);

  logic atStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      atStart <= 1'b1;
    end else if (dbValid) begin
      atStart <= dbLast;
    end
  end

  always_comb begin
    strb.stepEn   = dbValid;
    strb.colStart = dbValid & atStart;
  end

  for (genvar g = 0; g < NUM_PE; g++) begin : g_dec
    assign qryEn[g] = qryWe && (int'(qryIdx) == g);
  end

  // R8: at most one row is written per cycle
  a_r8_one_row: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(qryEn));

  // R7: after a closing symbol the next accepted one opens a new matrix
  a_r7_restart: assert property (@(posedge clk) disable iff (!rstN)
    (dbValid && dbLast) |=> (dbValid |-> strb.colStart));

  // R7: a symbol that follows a non-closing one continues the matrix
  a_r7_continue: assert property (@(posedge clk) disable iff (!rstN)
    (dbValid && !dbLast) |=> !strb.colStart);

endmodule

// File: rtl/seq_align_array.sv
module seq_align_array
  import seq_align_pkg::*;
#(
  parameter int NUM_PE   = 8,
  parameter int SYM_W    = 2,
  parameter int SCORE_W  = 16,
  parameter int MATCH_SC = 15,
  parameter int MISS_SC  = 12,
  parameter int GAP_SC   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  alnStrb_t           strb,
  input  logic [SYM_W-1:0]   dbSym,
  input  logic [NUM_PE-1:0]  qryEn,
  input  logic [SYM_W-1:0]   qrySym,
  output logic               resValid,
  output logic [SCORE_W-1:0] resScore
);

  // Index 0 is the array input; index k is the output of element k.
  logic               chValid [NUM_PE+1];
  logic               chStart [NUM_PE+1];
  logic [SYM_W-1:0]   chSym   [NUM_PE+1];
  logic [SCORE_W-1:0] chScore [NUM_PE+1];

  assign chValid[0] = strb.stepEn;
  assign chStart[0] = strb.colStart;
  assign chSym[0]   = dbSym;
  assign chScore[0] = '0;  // row 0 of the matrix

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    seq_align_pe #(
      .SYM_W(SYM_W), .SCORE_W(SCORE_W),
      .MATCH_SC(MATCH_SC), .MISS_SC(MISS_SC), .GAP_SC(GAP_SC)
    ) u_pe (
      .clk      (clk),
      .rstN     (rstN),
      .qryEn    (qryEn[g]),
      .qrySym   (qrySym),
      .inValid  (chValid[g]),
      .inStart  (chStart[g]),
      .inSym    (chSym[g]),
      .inUp     (chScore[g]),
      .outValid (chValid[g+1]),
      .outStart (chStart[g+1]),
      .outSym   (chSym[g+1]),
      .outScore (chScore[g+1])
    );
  end

  assign resValid = chValid[NUM_PE];
  assign resScore = chScore[NUM_PE];

endmodule

// File: rtl/seq_align_top.sv
module seq_align_top
  import seq_align_pkg::*;
#(
  parameter int NUM_PE   = 8,
  parameter int SYM_W    = 2,
  parameter int SCORE_W  = 16,
  parameter int MATCH_SC = 15,
  parameter int MISS_SC  = 12,
  parameter int GAP_SC   = 8,
  localparam int IDX_W   = $clog2(NUM_PE)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               qryWe,
  input  logic [IDX_W-1:0]   qryIdx,
  input  logic [SYM_W-1:0]   qrySym,
  input  logic               dbValid,
  input  logic [SYM_W-1:0]   dbSym,
  input  logic               dbLast,
  output logic               resValid,
  output logic [SCORE_W-1:0] resScore
);

  alnStrb_t          strb;
  logic [NUM_PE-1:0] qryEn;

  seq_align_ctrl #(.NUM_PE(NUM_PE)) u_ctrl (
    .clk(clk), .rstN(rstN), .dbValid(dbValid), .dbLast(dbLast),
    .qryWe(qryWe), .qryIdx(qryIdx), .strb(strb), .qryEn(qryEn)
  );

  seq_align_array #(
    .NUM_PE(NUM_PE), .SYM_W(SYM_W), .SCORE_W(SCORE_W),
    .MATCH_SC(MATCH_SC), .MISS_SC(MISS_SC), .GAP_SC(GAP_SC)
  ) u_array (
    .clk(clk), .rstN(rstN), .strb(strb), .dbSym(dbSym),
    .qryEn(qryEn), .qrySym(qrySym),
    .resValid(resValid), .resScore(resScore)
  );

endmodule

// File: tb/sim_seq_align_top.sv
module sim_seq_align_top;

  localparam int X = 8;
  localparam int MAXN = 128;
  localparam int MAXC = 512;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       qryWe = 1'b0;
  logic [2:0] qryIdx = '0;
  logic [1:0] qrySym = '0;
  logic       dbValid = 1'b0;
  logic [1:0] dbSym = '0;
  logic       dbLast = 1'b0;
  logic       resValid;
  logic [15:0] resScore;

  seq_align_top u0 (
    .clk(clk), .rstN(rstN), .qryWe(qryWe), .qryIdx(qryIdx), .qrySym(qrySym),
    .dbValid(dbValid), .dbSym(dbSym), .dbLast(dbLast),
    .resValid(resValid), .resScore(resScore)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFails  = 0;

  int qArr   [1:X];
  int dbArr  [MAXN];
  bit lastArr[MAXN];
  int expArr [MAXN];
  int cycIdx [MAXC];
  int mm     [0:X][0:MAXN];

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Dynamic-programming model for symbols base..base+len-1 (one sequence).
  task automatic model(int base, int len);
    int v;
    for (int i = 0; i <= X; i++) mm[i][0] = 0;
    for (int j = 0; j <= len; j++) mm[0][j] = 0;
    for (int j = 1; j <= len; j++) begin
      for (int i = 1; i <= X; i++) begin
        v = 0;
        if (mm[i][j-1] - 8 > v) v = mm[i][j-1] - 8;
        if (mm[i-1][j] - 8 > v) v = mm[i-1][j] - 8;
        if (mm[i-1][j-1] + ((qArr[i] == dbArr[base+j-1]) ? 15 : -12) > v)
          v = mm[i-1][j-1] + ((qArr[i] == dbArr[base+j-1]) ? 15 : -12);
        mm[i][j] = v;
      end
      expArr[base+j-1] = mm[X][j];
    end
    for (int j = 0; j < len; j++) lastArr[base+j] = (j == len-1);
  endtask

  task automatic loadQuery();
    for (int i = 1; i <= X; i++) begin
      @(negedge clk);
      qryWe = 1'b1; qryIdx = 3'(i-1); qrySym = 2'(qArr[i]);
    end
    @(negedge clk);
    qryWe = 1'b0;
  endtask

  // Drive n symbols from dbArr, with optional bubbles; check every cycle.
  task automatic runStream(string tag, int n, bit bubbles);
    int c = 0;
    int total;
    int k;
    for (int i = 0; i < MAXC; i++) cycIdx[i] = -1;
    for (int s = 0; s < n; s++) begin
      if (bubbles) c += int'($urandom_range(0, 2));
      cycIdx[c] = s;
      c++;
    end
    total = c + X + 2;
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      k = (t >= X) ? cycIdx[t-X] : -1;
      if (k >= 0) begin
        check({tag, " R5 valid"}, int'(resValid), 1);
        check({tag, " R4 score"}, int'(resScore), expArr[k]);
      end else begin
        check({tag, " R5 idle"}, int'(resValid), 0);
      end
      if (cycIdx[t] >= 0) begin
        dbValid = 1'b1; dbSym = 2'(dbArr[cycIdx[t]]); dbLast = lastArr[cycIdx[t]];
      end else begin
        dbValid = 1'b0; dbSym = 2'($urandom_range(0, 3)); dbLast = 1'($urandom_range(0, 1));
      end
    end
  endtask

  task automatic testReset();
    check("R9 reset valid", int'(resValid), 0);
    check("R9 reset score", int'(resScore), 0);
  endtask

  task automatic testIdentical();
    for (int i = 1; i <= X; i++) qArr[i] = (i - 1) % 4;
    loadQuery();
    for (int j = 0; j < 12; j++) dbArr[j] = j % 4;
    model(0, 12);
    runStream("R2 R3 identical", 12, 1'b0);
  endtask

  task automatic testNoMatch();
    for (int i = 1; i <= X; i++) qArr[i] = 0;
    loadQuery();
    for (int j = 0; j < 10; j++) dbArr[j] = 1 + (j % 3);
    model(0, 10);
    runStream("R10 nomatch", 10, 1'b0);
  endtask

  task automatic testRandom(string tag, bit bubbles);
    int len = int'($urandom_range(X + 1, 40));
    for (int i = 1; i <= X; i++) qArr[i] = int'($urandom_range(0, 3));
    loadQuery();
    for (int j = 0; j < len; j++) dbArr[j] = int'($urandom_range(0, 3));
    model(0, len);
    runStream(tag, len, bubbles);
  endtask

  task automatic testBackToBack();
    for (int i = 1; i <= X; i++) qArr[i] = int'($urandom_range(0, 3));
    loadQuery();
    // first sequence matches well, so a stale column would show
    for (int j = 0; j < 12; j++) dbArr[j] = qArr[(j % X) + 1];
    for (int j = 12; j < 24; j++) dbArr[j] = int'($urandom_range(0, 3));
    for (int j = 24; j < 33; j++) dbArr[j] = qArr[((j - 24) % X) + 1];
    model(0, 12);
    model(12, 12);
    model(24, 9);
    runStream("R1 R7 back-to-back", 33, 1'b1);
  endtask

  task automatic testRowWrite();
    for (int i = 1; i <= X; i++) qArr[i] = 0;
    loadQuery();
    @(negedge clk);
    qryWe = 1'b1; qryIdx = 3'd4; qrySym = 2'd3;  // row 5
    qArr[5] = 3;
    @(negedge clk);
    qryWe = 1'b0;
    for (int j = 0; j < 14; j++) dbArr[j] = (j % 2 == 0) ? 3 : 0;
    model(0, 14);
    runStream("R8 row write", 14, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdentical();
    testNoMatch();
    testRandom("R2 random a", 1'b0);
    testRandom("R2 random b", 1'b0);
    testRandom("R6 bubbles a", 1'b1);
    testRandom("R6 bubbles b", 1'b1);
    testBackToBack();
    testRowWrite();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule